// File: doc/BRIEF.md
# Current-Mode PWM Cycle Controller

This block is the digital core of a fixed-frequency, current-mode switching regulator stage. A period timer counts system-clock cycles and marks the start of every switching period. At that mark the gate latch turns the power switch on. The latch is cleared, and the gate drops, when the on-time limit is reached or when one of several comparator flags is seen. The flags are already digitised and synchronous to the clock: an error-amplifier comparison, a soft-start ceiling, a normal current limit and a reduced current limit.

The current-sense flags (error comparison, normal limit, reduced limit) are blanked during the first on-cycles of each pulse, so the turn-on spike cannot end the pulse early. The reduced current limit only counts while the burst input is high. The soft-start flag is never blanked. An undervoltage indication forces the gate low at once and keeps it low. Two period lengths can be chosen, and the on-time ceiling of each is a fixed percentage of its period. With defaults at a 50 MHz clock, the fast rate is 500 cycles (100 kHz) with a 360-cycle ceiling, and blanking lasts 11 cycles.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: The period is PERIOD_FAST cycles when `rate_sel` is 0 and PERIOD_SLOW cycles when it is 1. `rate_sel` is sampled during reset and in the last cycle of each period, so a change takes effect at the next period boundary.
- R2: After reset is released, the first cycle is on-cycle index 0 of a period. The gate is high from index 1 of each period unless a clearing condition intervenes, and it is always low at index 0.
- R3: The gate is high for at most MAX_ON = PERIOD*DUTY_PCT/100 cycles per period (integer division), ending after index MAX_ON.
- R4: `pwm_flag` high in index c ≥ BLANK, while the gate is high, drives the gate low from index c+1. The gate then stays low until the next period, even if the flag falls again.
- R5: `ilim_flag` behaves as in R4.
- R6: Sense flags present only in indices below BLANK are ignored. A sense flag that is held high through the whole period gives a pulse of exactly BLANK cycles.
- R7: `ilim_low_flag` acts as a sense flag (as in R4 and R6) only while `burst_en` is 1. While `burst_en` is 0 it has no effect, and the pulse lasts MAX_ON cycles.
- R8: `ss_flag` is not blanked. High in index c ≥ 1, it drives the gate low from c+1. High at index 0, it stops the gate from turning on in that period.
- R9: `uvlo` high in any cycle forces the gate low in the next cycle. The gate stays low for the rest of that period. If `uvlo` is high at index 0, the gate does not turn on in that period.
- R10: While `rst` is high the gate is low, and the period position is held at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Period select: 0 fast, 1 slow |
| uvlo | input | 1 | Supply below off threshold when high |
| burst_en | input | 1 | Enables the reduced current-limit flag |
| pwm_flag | input | 1 | Error-amplifier comparator tripped |
| ss_flag | input | 1 | Soft-start ceiling reached |
| ilim_flag | input | 1 | Normal current limit reached |
| ilim_low_flag | input | 1 | Reduced current limit reached |
| gate | output | 1 | Registered drive to the power switch |

## Verification
The hardest cases sit at the edge of the blanking window: a flag that arrives in the last blanked cycle and another that arrives in the first unblanked one. The end of the window can only be found by counting cycles from the start of the period. The bench therefore keeps its own period position from reset release and sweeps the start index of each flag (one-cycle and three-cycle pulses) across every index from 0 to MAX_ON+1, for each flag kind and both rates. It computes each expected pulse width arithmetically from that position.

// File: rtl/pwm_cycle_pkg.sv
package pwm_cycle_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // on-time ceiling in cycles for a period and duty percentage
  function automatic int unsigned on_ceiling(int unsigned period, int unsigned pct);
    return (period * pct) / 100;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwm_cycle_pkg::*;
#(
  parameter int unsigned PERIOD_FAST = 500,
  parameter int unsigned PERIOD_SLOW = 746,
  parameter int unsigned DUTY_PCT    = 72,
  parameter int unsigned CW          = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_sel,
  output logic [CW-1:0] count,
  output logic          start,
  output logic          at_ceiling
);

  localparam logic [CW-1:0] LAST_F = CW'(PERIOD_FAST - 1);
  localparam logic [CW-1:0] LAST_S = CW'(PERIOD_SLOW - 1);
  localparam logic [CW-1:0] CEIL_F = CW'(on_ceiling(PERIOD_FAST, DUTY_PCT));
  localparam logic [CW-1:0] CEIL_S = CW'(on_ceiling(PERIOD_SLOW, DUTY_PCT));

  rate_e         rate_q;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] ceil_idx;
  logic          wrap;

  always_comb begin
    last_idx = (rate_q == RATE_SLOW) ? LAST_S : LAST_F;
    ceil_idx = (rate_q == RATE_SLOW) ? CEIL_S : CEIL_F;
    wrap     = (count == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      rate_q <= rate_e'(rate_sel);
    end else if (wrap) begin
      count  <= '0;
      rate_q <= rate_e'(rate_sel);
    end else begin
      count  <= count + 1'b1;
    end
  end

  assign start      = (count == '0);
  assign at_ceiling = (count >= ceil_idx);

endmodule

// File: rtl/pwm_blank_mask.sv
module pwm_blank_mask #(
  parameter int unsigned BLANK = 11,
  parameter int unsigned CW    = 10,
  parameter int unsigned NSENSE = 3
) (
  input  logic [CW-1:0]     count,
  input  logic [NSENSE-1:0] sense,
  input  logic [NSENSE-1:0] sense_en,
  output logic              trip
);

  localparam logic [CW-1:0] OPEN_IDX = CW'(BLANK);

  logic [NSENSE-1:0] qual;
  logic              window_open;

  assign window_open = (count >= OPEN_IDX);

  for (genvar i = 0; i < NSENSE; i++) begin : g_qual
    assign qual[i] = sense[i] & sense_en[i];
  end

  assign trip = window_open & (|qual);

endmodule

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl
  import pwm_cycle_pkg::*;
#(
  parameter int unsigned PERIOD_FAST = 500,
  parameter int unsigned PERIOD_SLOW = 746,
  parameter int unsigned DUTY_PCT    = 72,
  parameter int unsigned BLANK       = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  input  logic uvlo,
  input  logic burst_en,
  input  logic pwm_flag,
  input  logic ss_flag,
  input  logic ilim_flag,
  input  logic ilim_low_flag,
  output logic gate
);

  localparam int unsigned PMAX   = max2(PERIOD_FAST, PERIOD_SLOW);
  localparam int unsigned CW     = $clog2(PMAX + 1);
  localparam int unsigned NSENSE = 3;

  logic [CW-1:0]     count;
  logic              start;
  logic              at_ceiling;
  logic              sense_trip;
  logic [NSENSE-1:0] sense_vec;
  logic [NSENSE-1:0] sense_en;
  logic              gate_q;
  logic              gate_d;

  pwm_period_timer #(
    .PERIOD_FAST(PERIOD_FAST),
    .PERIOD_SLOW(PERIOD_SLOW),
    .DUTY_PCT   (DUTY_PCT),
    .CW         (CW)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .count     (count),
    .start     (start),
    .at_ceiling(at_ceiling)
  );

  assign sense_vec = {ilim_low_flag, ilim_flag, pwm_flag};
  assign sense_en  = {burst_en, 1'b1, 1'b1};

  pwm_blank_mask #(
    .BLANK (BLANK),
    .CW    (CW),
    .NSENSE(NSENSE)
  ) u_mask (
    .count   (count),
    .sense   (sense_vec),
    .sense_en(sense_en),
    .trip    (sense_trip)
  );

  always_comb begin
    if (uvlo) begin
      gate_d = 1'b0;
    end else if (start) begin
      gate_d = ~ss_flag;
    end else if (gate_q && (ss_flag || sense_trip || at_ceiling)) begin
      gate_d = 1'b0;
    end else begin
      gate_d = gate_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_d;
  end

  assign gate = gate_q;

endmodule

// File: rtl/pwm_cycle_ctrl_chk.sv
module pwm_cycle_ctrl_chk
  import pwm_cycle_pkg::*;
#(
  parameter int unsigned PERIOD_FAST = 500,
  parameter int unsigned PERIOD_SLOW = 746,
  parameter int unsigned DUTY_PCT    = 72,
  parameter int unsigned BLANK       = 11
) (
  input logic clk,
  input logic rst,
  input logic uvlo,
  input logic burst_en,
  input logic pwm_flag,
  input logic ss_flag,
  input logic ilim_flag,
  input logic ilim_low_flag,
  input logic gate
);

  localparam int unsigned CAP = max2(on_ceiling(PERIOD_FAST, DUTY_PCT),
                                     on_ceiling(PERIOD_SLOW, DUTY_PCT));
  localparam logic [15:0] CAP16   = 16'(CAP);
  localparam logic [15:0] OPEN16  = 16'(BLANK - 1);

  // cycles the gate has already been high before the current one
  logic [15:0] on_len;
  always_ff @(posedge clk) begin
    if (rst || !gate) on_len <= '0;
    else              on_len <= on_len + 1'b1;
  end

  p_uvlo_off_r9: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> !gate);

  p_ss_off_r8: assert property (@(posedge clk) disable iff (rst)
    ss_flag |=> !gate);

  p_on_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    gate |-> (on_len < CAP16));

  p_sense_trip_r4: assert property (@(posedge clk) disable iff (rst)
    (gate && on_len >= OPEN16 && (pwm_flag || ilim_flag)) |=> !gate);

  p_burst_trip_r7: assert property (@(posedge clk) disable iff (rst)
    (gate && on_len >= OPEN16 && burst_en && ilim_low_flag) |=> !gate);

  if (BLANK > 1 && CAP > 1) begin : g_blank
    p_blank_hold_r6: assert property (@(posedge clk) disable iff (rst)
      ($rose(gate) && !uvlo && !ss_flag) |=> gate);
  end

endmodule

bind pwm_cycle_ctrl pwm_cycle_ctrl_chk #(
  .PERIOD_FAST(PERIOD_FAST),
  .PERIOD_SLOW(PERIOD_SLOW),
  .DUTY_PCT   (DUTY_PCT),
  .BLANK      (BLANK)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .uvlo         (uvlo),
  .burst_en     (burst_en),
  .pwm_flag     (pwm_flag),
  .ss_flag      (ss_flag),
  .ilim_flag    (ilim_flag),
  .ilim_low_flag(ilim_low_flag),
  .gate         (gate)
);

// File: tb/pwm_cycle_ctrl_test.sv
module pwm_cycle_ctrl_test;

  localparam int PF = 20;
  localparam int PS = 30;
  localparam int BL = 3;
  localparam int DP = 72;
  localparam int MF = PF * DP / 100;
  localparam int MS = PS * DP / 100;
  localparam int NONE = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b0;
  logic uvlo = 1'b0;
  logic burst_en = 1'b0;
  logic pwm_flag = 1'b0;
  logic ss_flag = 1'b0;
  logic ilim_flag = 1'b0;
  logic ilim_low_flag = 1'b0;
  logic gate;

  int n_chk = 0;
  int n_bad = 0;
  bit cur_sel = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwm_cycle_ctrl #(
    .PERIOD_FAST(PF), .PERIOD_SLOW(PS), .DUTY_PCT(DP), .BLANK(BL)
  ) uut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .uvlo(uvlo),
    .burst_en(burst_en), .pwm_flag(pwm_flag), .ss_flag(ss_flag),
    .ilim_flag(ilim_flag), .ilim_low_flag(ilim_low_flag), .gate(gate)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // kind: 0 pwm, 1 ilim, 2 reduced limit in burst, 3 reduced limit outside burst,
  //       4 soft-start, 5 undervoltage, 6 none
  task automatic run_period(input int kind, input int a, input int len, input bit nxt_sel);
    int p, m, width, first, exp_w, cf, s;
    string tag;
    p = cur_sel ? PS : PF;
    m = cur_sel ? MS : MF;
    width = 0;
    first = -1;
    for (int c = 0; c < p; c++) begin
      bit act;
      if (gate === 1'b1) begin
        width++;
        if (first < 0) first = c;
      end
      act = (c >= a) && (c < a + len);
      pwm_flag      = (kind == 0) && act;
      ilim_flag     = (kind == 1) && act;
      ilim_low_flag = (kind == 2 || kind == 3) && act;
      burst_en      = (kind == 2);
      ss_flag       = (kind == 4) && act;
      uvlo          = (kind == 5) && act;
      if (c == p - 1) rate_sel = nxt_sel;
      @(negedge clk);
    end
    pwm_flag = 0; ilim_flag = 0; ilim_low_flag = 0; ss_flag = 0; uvlo = 0; burst_en = 0;
    case (kind)
      0, 1, 2: begin
        s  = imax(a, BL);
        cf = (s <= a + len - 1) ? s : NONE;
        exp_w = imin(m, cf);
      end
      4, 5: exp_w = imin(m, a);
      default: exp_w = m;
    endcase
    case (kind)
      0: tag = (a < BL) ? "R6 pwm blank" : "R4 pwm trip";
      1: tag = (a < BL) ? "R6 ilim blank" : "R5 ilim trip";
      2: tag = "R7 reduced limit in burst";
      3: tag = "R7 reduced limit ignored";
      4: tag = "R8 soft-start";
      5: tag = "R9 undervoltage";
      default: tag = "R3 ceiling";
    endcase
    check(tag, width, exp_w);
    // contiguous pulse starting at index 1 (R1 period position, R2 set point)
    check("R2 pulse start", first, (exp_w > 0) ? 1 : -1);
    cur_sel = nxt_sel;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: gate low during reset, even with no flag asserted
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 reset gate", int'(gate), 0);
    end
    rst = 1'b0;
    // R1/R3: clean periods alternating the rate
    run_period(6, NONE, 1, 1'b0);
    run_period(6, NONE, 1, 1'b1);
    run_period(6, NONE, 1, 1'b0);
    run_period(6, NONE, 1, 1'b1);
    run_period(6, NONE, 1, 1'b1);
    run_period(6, NONE, 1, 1'b0);
    // R4..R9: sweep of flag start index and length, both rates
    for (int sel = 0; sel < 2; sel++) begin
      // align the rate for this sweep
      run_period(6, NONE, 1, sel[0]);
      for (int kind = 0; kind < 6; kind++) begin
        for (int li = 0; li < 2; li++) begin
          int m = sel ? MS : MF;
          for (int a = 0; a <= m + 1; a++) begin
            run_period(kind, a, li ? 3 : 1, sel[0]);
          end
        end
      end
      // R6: sense flag held for the whole period gives exactly BL cycles
      run_period(0, 0, 40, sel[0]);
      run_period(1, 0, 40, sel[0]);
      run_period(2, 0, 40, sel[0]);
    end
    // R10: reset in mid-period returns to index 0
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 mid-run reset gate", int'(gate), 0);
    rate_sel = 1'b0;
    @(negedge clk);
    cur_sel = 1'b0;
    rst = 1'b0;
    run_period(6, NONE, 1, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule